// File: doc/BRIEF.md
# Jittered Foldback PWM Timebase

This block is the digital clock generator for a fixed-frequency, peak-current-mode switching converter. It counts a fast reference clock and produces a one-cycle pulse that starts each switching cycle and a second pulse that forces the on-time to end at a fixed fraction of the period. A static configuration input picks one of two nominal switching rates. A slow triangular dither moves the period up and down around its base value to spread the switching spectrum, and the dither keeps running when the rate is folded back.

The feedback level from the voltage loop arrives as an unsigned code in millivolts. One code drives three things. It sets the base period: nominal at high load, stretched linearly toward a minimum rate as the load falls. It drives a skip comparator with hysteresis that stops cycles at very light load. It also sets a clamped peak-current setpoint code for the external current comparator. A new period length and dither offset are taken only when a period ends, so a running cycle is never cut short or stretched.

Top module: `jfb_timebase`

## Requirements
- R1: While reset is held, and after it, cycle-start and max-duty pulses are low, skip is low and the setpoint code is 250. The first cycle-start pulse appears exactly the nominal period count (100 clocks for the low rate, 65 for the high rate) after reset is released.
- R2: With feedback at or above 1500 mV, the base period is the nominal count: REF_KHZ / 65 = 100 clocks when freq_sel_i = 0, and REF_KHZ / 100 = 65 clocks when freq_sel_i = 1 (REF_KHZ = 6500). freq_sel_i is static and changes only under reset.
- R3: The max-duty pulse of each started cycle comes floor(P * 80 / 100) clocks after that cycle's start pulse, where P is that cycle's length. It never coincides with a start pulse.
- R4: Every period equals base + d. The dither offset d starts at 0 after reset and moves in a triangle between -J and +J, first upward, by one count after every H period boundaries. J = floor(nominal * 5 / 100) gives 5 or 3. H is 13 or 34, which gives a sweep of about 240 Hz. The offset used by a period is the value held before the step made at the boundary that loads it.
- R5: The dither keeps running unchanged while the period is folded back.
- R6: Below 1500 mV the base period is nominal + floor((250 - nominal) * (1500 - fb) / 1050). At or below 450 mV it is 250 clocks (the 26 kHz minimum).
- R7: A feedback change during a period does not alter that period. The new base applies from the next boundary on.
- R8: Skip turns on when feedback is below 400 mV. It turns off only when feedback reaches 440 mV or more, and holds its state in between. skip_o follows feedback one clock later.
- R9: A period that begins while skip is on produces no start pulse and no max-duty pulse. Pulses resume at the first boundary after skip has cleared.
- R10: The setpoint code is floor(fb / 4). Below 1000 mV it is held at 250, and above 3200 mV it is clamped to 800. It updates one clock after feedback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Synchronous reset, active low |
| freq_sel_i | input | 1 | Nominal rate select: 0 low rate, 1 high rate |
| fb_mv_i | input | FB_W (12) | Feedback level in millivolts |
| cyc_set_o | output | 1 | One-clock pulse that starts a switching cycle |
| max_duty_o | output | 1 | One-clock pulse that ends the on-time at the duty limit |
| skip_o | output | 1 | Skip mode active |
| ipk_code_o | output | SP_W (10) | Peak-current setpoint code in millivolts |

## Verification
The setpoint and the skip flag each pass through one register after the feedback input, so the bench drives feedback just after a falling edge and samples them at the next falling edge. Cycle-start pulses come one clock after the counter's final count. Periods are therefore measured as the distance between consecutive start pulses, and the max-duty result as the distance from a start pulse, and each is compared against a queue of expected lengths that a model of the dither triangle fills in advance. Feedback is changed only right after a start pulse, so the running period keeps the old base, is tagged as the hold-over check, and every later period takes the new one.

// File: rtl/jfb_pkg.sv
package jfb_pkg;

   typedef enum logic {
      DIR_UP = 1'b0,
      DIR_DN = 1'b1
   } tri_dir_e;

   function automatic int pct_of(input int value, input int pct);
      return (value * pct) / 100;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

   function automatic int imin(input int a, input int b);
      return (a < b) ? a : b;
   endfunction

endpackage

// File: rtl/jfb_dither.sv
module jfb_dither
   import jfb_pkg::*;
#(
   parameter int JW = 4,
   parameter int HW = 6,
   parameter bit EN = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 step_i,
   input  logic [JW-1:0]        jmax_i,
   input  logic [HW-1:0]        hold_i,
   output logic signed [JW-1:0] dith_o
);

   generate
      if (EN) begin : g_tri
         localparam logic signed [JW-1:0] ONE = JW'(1);
         logic signed [JW-1:0] d_q;
         logic signed [JW-1:0] lim;
         tri_dir_e             dir_q;
         logic [HW-1:0]        hc_q;

         assign lim    = $signed(jmax_i);
         assign dith_o = d_q;

         always_ff @(posedge clk) begin
            if (!rst_n) begin
               d_q   <= '0;
               dir_q <= DIR_UP;
               hc_q  <= '0;
            end else if (step_i) begin
               if (hc_q == hold_i - HW'(1)) begin
                  hc_q <= '0;
                  if (dir_q == DIR_UP) begin
                     if (d_q >= lim) begin
                        dir_q <= DIR_DN;
                        d_q   <= d_q - ONE;
                     end else begin
                        d_q   <= d_q + ONE;
                     end
                  end else begin
                     if (d_q <= -lim) begin
                        dir_q <= DIR_UP;
                        d_q   <= d_q + ONE;
                     end else begin
                        d_q   <= d_q - ONE;
                     end
                  end
               end else begin
                  hc_q <= hc_q + HW'(1);
               end
            end
         end

         AST_DITH_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
            (d_q <= lim) && (d_q >= -lim)); // R4
         AST_DITH_HELD: assert property (@(posedge clk) disable iff (!rst_n)
            !step_i |=> $stable(d_q)); // R4
      end else begin : g_flat
         assign dith_o = '0;
      end
   endgenerate

endmodule

// File: rtl/jfb_fbmap.sv
module jfb_fbmap #(
   parameter int FB_W        = 12,
   parameter int PER_W       = 8,
   parameter int SP_W        = 10,
   parameter int PER_A       = 100,
   parameter int PER_B       = 65,
   parameter int PER_MIN     = 250,
   parameter int FOLD_MV     = 1500,
   parameter int FOLD_END_MV = 450,
   parameter int SKIP_MV     = 400,
   parameter int SKIP_HYS_MV = 40,
   parameter int FREEZE_MV   = 1000,
   parameter int SP_TOP_MV   = 3200,
   parameter int SP_DIV      = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel_i,
   input  logic [FB_W-1:0]  fb_i,
   output logic [PER_W-1:0] base_o,
   output logic             skip_o,
   output logic [SP_W-1:0]  sp_o
);

   localparam logic [FB_W-1:0] SKIP_ON_C  = FB_W'(SKIP_MV);
   localparam logic [FB_W-1:0] SKIP_OFF_C = FB_W'(SKIP_MV + SKIP_HYS_MV);
   localparam int              SPAN       = FOLD_MV - FOLD_END_MV;
   localparam int              SP_LO      = FREEZE_MV / SP_DIV;
   localparam int              SP_HI      = SP_TOP_MV / SP_DIV;

   logic [31:0]      fb32;
   logic [31:0]      pnom32;
   logic [31:0]      base32;
   logic [31:0]      sp32;
   logic [PER_W-1:0] base_q;
   logic             skip_q;
   logic [SP_W-1:0]  sp_q;

   always_comb begin
      fb32   = 32'(fb_i);
      pnom32 = sel_i ? 32'(PER_B) : 32'(PER_A);
      if (fb32 >= 32'(FOLD_MV)) begin
         base32 = pnom32;
      end else if (fb32 <= 32'(FOLD_END_MV)) begin
         base32 = 32'(PER_MIN);
      end else begin
         base32 = pnom32 + ((32'(PER_MIN) - pnom32) * (32'(FOLD_MV) - fb32)) / 32'(SPAN);
      end
      if (fb32 < 32'(FREEZE_MV)) begin
         sp32 = 32'(SP_LO);
      end else if (fb32 > 32'(SP_TOP_MV)) begin
         sp32 = 32'(SP_HI);
      end else begin
         sp32 = fb32 / 32'(SP_DIV);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         base_q <= sel_i ? PER_W'(PER_B) : PER_W'(PER_A);
         skip_q <= 1'b0;
         sp_q   <= SP_W'(SP_LO);
      end else begin
         base_q <= PER_W'(base32);
         sp_q   <= SP_W'(sp32);
         if (fb_i < SKIP_ON_C) begin
            skip_q <= 1'b1;
         end else if (fb_i >= SKIP_OFF_C) begin
            skip_q <= 1'b0;
         end
      end
   end

   assign base_o = base_q;
   assign skip_o = skip_q;
   assign sp_o   = sp_q;

   AST_SKIP_BAND_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (fb_i >= SKIP_ON_C) && (fb_i < SKIP_OFF_C) |=> $stable(skip_q)); // R8
   AST_SP_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (sp_q >= SP_W'(SP_LO)) && (sp_q <= SP_W'(SP_HI))); // R10
   AST_BASE_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      base_q <= PER_W'(PER_MIN)); // R6

endmodule

// File: rtl/jfb_timebase.sv
module jfb_timebase
   import jfb_pkg::*;
#(
   parameter int REF_KHZ     = 6500,
   parameter int FNOM_A_KHZ  = 65,
   parameter int FNOM_B_KHZ  = 100,
   parameter int FMIN_KHZ    = 26,
   parameter int JIT_PCT     = 5,
   parameter int MOD_HZ      = 240,
   parameter int DUTY_PCT    = 80,
   parameter int FB_W        = 12,
   parameter int SP_W        = 10,
   parameter int FOLD_MV     = 1500,
   parameter int FOLD_END_MV = 450,
   parameter int SKIP_MV     = 400,
   parameter int SKIP_HYS_MV = 40,
   parameter int FREEZE_MV   = 1000,
   parameter int SP_TOP_MV   = 3200,
   parameter int SP_DIV      = 4
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            freq_sel_i,
   input  logic [FB_W-1:0] fb_mv_i,
   output logic            cyc_set_o,
   output logic            max_duty_o,
   output logic            skip_o,
   output logic [SP_W-1:0] ipk_code_o
);

   localparam int PER_A   = REF_KHZ / FNOM_A_KHZ;
   localparam int PER_B   = REF_KHZ / FNOM_B_KHZ;
   localparam int PER_MIN = REF_KHZ / FMIN_KHZ;
   localparam int JIT_A   = pct_of(PER_A, JIT_PCT);
   localparam int JIT_B   = pct_of(PER_B, JIT_PCT);
   localparam int JMAX    = imax(JIT_A, JIT_B);
   localparam int HOLD_A  = imax(1, (FNOM_A_KHZ * 1000 / MOD_HZ) / (4 * imax(JIT_A, 1)));
   localparam int HOLD_B  = imax(1, (FNOM_B_KHZ * 1000 / MOD_HZ) / (4 * imax(JIT_B, 1)));
   localparam int HMAX    = imax(HOLD_A, HOLD_B);
   localparam int PER_MAX = PER_MIN + JMAX;
   localparam int PER_LO  = imin(PER_A, PER_B) - JMAX;
   localparam int PER_W   = $clog2(PER_MAX + 1);
   localparam int JW      = $clog2(JMAX + 1) + 1;
   localparam int HW      = $clog2(HMAX + 1);
   localparam int SW      = PER_W + 2;
   localparam int DMAX_A  = pct_of(PER_A, DUTY_PCT);
   localparam int DMAX_B  = pct_of(PER_B, DUTY_PCT);

   generate
      if (PER_A >= PER_MIN || PER_B >= PER_MIN) begin : g_bad_rates
         $error("nominal periods must be shorter than the folded minimum-rate period");
      end
      if (DUTY_PCT <= 0 || DUTY_PCT >= 100) begin : g_bad_duty
         $error("duty limit must lie strictly between 0 and 100 percent");
      end
      if (FOLD_MV <= FOLD_END_MV || FOLD_END_MV < SKIP_MV) begin : g_bad_fold
         $error("foldback thresholds out of order");
      end
      if (SP_TOP_MV / SP_DIV >= (1 << SP_W) || FB_W > 16) begin : g_bad_width
         $error("setpoint or feedback width too small or too large");
      end
      if (PER_LO < 4) begin : g_bad_lo
         $error("dithered period too short for the duty counter");
      end
   endgenerate

   logic [PER_W-1:0]      cnt_q;
   logic [PER_W-1:0]      per_q;
   logic [PER_W-1:0]      dmax_q;
   logic                  set_q;
   logic                  mx_q;
   logic                  live_q;
   logic                  wrap;
   logic [PER_W-1:0]      base;
   logic                  skip;
   logic signed [JW-1:0]  dith;
   logic signed [SW-1:0]  sum;
   logic [PER_W-1:0]      per_nx;
   logic [PER_W-1:0]      dmax_nx;

   jfb_fbmap #(
      .FB_W(FB_W), .PER_W(PER_W), .SP_W(SP_W),
      .PER_A(PER_A), .PER_B(PER_B), .PER_MIN(PER_MIN),
      .FOLD_MV(FOLD_MV), .FOLD_END_MV(FOLD_END_MV),
      .SKIP_MV(SKIP_MV), .SKIP_HYS_MV(SKIP_HYS_MV),
      .FREEZE_MV(FREEZE_MV), .SP_TOP_MV(SP_TOP_MV), .SP_DIV(SP_DIV)
   ) i_fbmap (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel_i  (freq_sel_i),
      .fb_i   (fb_mv_i),
      .base_o (base),
      .skip_o (skip),
      .sp_o   (ipk_code_o)
   );

   jfb_dither #(
      .JW(JW), .HW(HW), .EN(JMAX > 0)
   ) i_dither (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (wrap),
      .jmax_i (freq_sel_i ? JW'(JIT_B) : JW'(JIT_A)),
      .hold_i (freq_sel_i ? HW'(HOLD_B) : HW'(HOLD_A)),
      .dith_o (dith)
   );

   assign wrap = (cnt_q == per_q - PER_W'(1));

   always_comb begin
      sum     = SW'($signed({1'b0, base})) + SW'(dith);
      per_nx  = PER_W'(sum);
      dmax_nx = PER_W'((32'(per_nx) * 32'(DUTY_PCT)) / 32'(100));
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         per_q  <= freq_sel_i ? PER_W'(PER_B) : PER_W'(PER_A);
         dmax_q <= freq_sel_i ? PER_W'(DMAX_B) : PER_W'(DMAX_A);
         set_q  <= 1'b0;
         mx_q   <= 1'b0;
         live_q <= 1'b0;
      end else begin
         mx_q <= live_q && !wrap && (cnt_q == dmax_q - PER_W'(1));
         if (wrap) begin
            cnt_q  <= '0;
            per_q  <= per_nx;
            dmax_q <= dmax_nx;
            set_q  <= !skip;
            live_q <= !skip;
         end else begin
            cnt_q  <= cnt_q + PER_W'(1);
            set_q  <= 1'b0;
         end
      end
   end

   assign cyc_set_o  = set_q;
   assign max_duty_o = mx_q;
   assign skip_o     = skip;

   AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(set_q && mx_q)); // R3
   AST_DUTY_INSIDE: assert property (@(posedge clk) disable iff (!rst_n)
      dmax_q < per_q); // R3
   AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !wrap |=> $stable(per_q)); // R7
   AST_PER_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
      (per_q >= PER_W'(PER_LO)) && (per_q <= PER_W'(PER_MAX))); // R4
   AST_SKIP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      skip |=> !set_q); // R9

endmodule

// File: tb/test_jfb_timebase.sv
module test_jfb_timebase;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        freq_sel = 1'b0;
   logic [11:0] fb_mv = 12'd2000;
   logic        cyc_set;
   logic        max_duty;
   logic        skip;
   logic [9:0]  ipk_code;

   always #4 clk = ~clk;

   jfb_timebase i_jfb_timebase (
      .clk        (clk),
      .rst_n      (rst_n),
      .freq_sel_i (freq_sel),
      .fb_mv_i    (fb_mv),
      .cyc_set_o  (cyc_set),
      .max_duty_o (max_duty),
      .skip_o     (skip),
      .ipk_code_o (ipk_code)
   );

   int    n_run = 0;
   int    n_fail = 0;
   int    exp_per_q[$];
   int    exp_on_q[$];
   string exp_tag_q[$];
   bit    sb_on = 1'b0;
   bit    seen = 1'b0;
   int    tick = 0;
   int    t_last = 0;
   int    md, mhold, mj, mh, mpnom;
   bit    mup;

   task automatic chk(input string req, input int act, input int exp);
      n_run++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int base_of(input int fb);
      if (fb >= 1500) return mpnom;
      if (fb <= 450) return 250;
      return mpnom + ((250 - mpnom) * (1500 - fb)) / 1050;
   endfunction

   // expected period queue: base plus held dither, then the triangle steps
   task automatic push_period(input int fb, input string tag);
      int p;
      p = base_of(fb) + md;
      exp_per_q.push_back(p);
      exp_on_q.push_back((p * 80) / 100);
      exp_tag_q.push_back(tag);
      if (mhold == mh - 1) begin
         mhold = 0;
         if (mup) begin
            if (md >= mj) begin mup = 1'b0; md = md - 1; end
            else md = md + 1;
         end else begin
            if (md <= -mj) begin mup = 1'b1; md = md + 1; end
            else md = md - 1;
         end
      end else begin
         mhold = mhold + 1;
      end
   endtask

   // monitor: measures periods and on-time limits, pops and compares
   always @(negedge clk) begin
      if (sb_on) begin
         tick++;
         if (cyc_set) begin
            if (seen) begin
               if (exp_per_q.size() == 0) chk("R4 unexpected period", 1, 0);
               else chk(exp_tag_q.pop_front(), tick - t_last, exp_per_q.pop_front());
            end
            seen = 1'b1;
            t_last = tick;
         end
         if (max_duty && seen) begin
            if (exp_on_q.size() == 0) chk("R3 unexpected duty pulse", 1, 0);
            else chk("R3 duty limit", tick - t_last, exp_on_q.pop_front());
         end
      end
   end

   task automatic wait_sets(input int n);
      repeat (n) begin
         @(negedge clk);
         while (!cyc_set) @(negedge clk);
      end
   endtask

   // called at the negedge where a start pulse was seen
   task automatic run_phase(input int fb, input int n, input string tag, input int sp_exp);
      exp_tag_q[exp_tag_q.size() - 1] = "R7 running period kept old base";
      fb_mv = 12'(fb);
      @(negedge clk);
      chk("R10 setpoint", int'(ipk_code), sp_exp);
      for (int i = 0; i < n; i++) push_period(fb, tag);
      wait_sets(n);
   endtask

   task automatic session(input bit sel, input int f0);
      int k;
      sb_on = 1'b0;
      rst_n = 1'b0;
      freq_sel = sel;
      fb_mv = 12'(f0);
      exp_per_q.delete();
      exp_on_q.delete();
      exp_tag_q.delete();
      mpnom = sel ? 65 : 100;
      mj = sel ? 3 : 5;
      mh = sel ? 34 : 13;
      md = 0; mhold = 0; mup = 1'b1;
      repeat (5) @(negedge clk);
      chk("R1 set low in reset", int'(cyc_set), 0);
      chk("R1 duty low in reset", int'(max_duty), 0);
      chk("R1 skip low in reset", int'(skip), 0);
      chk("R1 setpoint in reset", int'(ipk_code), 250);
      push_period(f0, "R2 R4 first period");
      seen = 1'b0;
      tick = 0;
      sb_on = 1'b1;
      rst_n = 1'b1;
      k = 0;
      do begin
         @(negedge clk);
         k++;
      end while (!cyc_set);
      chk("R1 first start delay", k, mpnom);
   endtask

   task automatic drain;
      while (exp_per_q.size() != 0) @(negedge clk);
      sb_on = 1'b0;
      chk("R3 duty queue drained", exp_on_q.size(), 0);
   endtask

   task automatic main;
      int cnt_set, cnt_mx, found;
      session(1'b0, 2000);
      run_phase(2000, 280, "R2 R4 nominal low rate", 500);
      run_phase(975, 40, "R5 R6 folded mid", 250);
      run_phase(450, 20, "R6 minimum rate", 250);
      run_phase(500, 20, "R6 R5 near minimum", 250);
      run_phase(3000, 10, "R2 back to nominal", 750);
      run_phase(4000, 5, "R2 top feedback", 800);
      drain();

      session(1'b1, 2000);
      run_phase(2000, 420, "R2 R4 nominal high rate", 500);
      run_phase(1000, 20, "R5 R6 folded high rate", 250);
      run_phase(3300, 5, "R2 high rate clamp", 800);
      drain();

      fb_mv = 12'd400;
      @(negedge clk);
      chk("R8 400 mV does not enter skip", int'(skip), 0);
      fb_mv = 12'd399;
      @(negedge clk);
      chk("R8 399 mV enters skip", int'(skip), 1);
      fb_mv = 12'd439;
      @(negedge clk);
      chk("R8 439 mV stays in skip", int'(skip), 1);
      repeat (300) @(negedge clk);
      cnt_set = 0;
      cnt_mx = 0;
      for (int i = 0; i < 600; i++) begin
         @(negedge clk);
         if (cyc_set) cnt_set++;
         if (max_duty) cnt_mx++;
      end
      chk("R9 no start pulses in skip", cnt_set, 0);
      chk("R9 no duty pulses in skip", cnt_mx, 0);
      fb_mv = 12'd440;
      @(negedge clk);
      chk("R8 440 mV leaves skip", int'(skip), 0);
      found = 0;
      for (int i = 0; i < 300 && found == 0; i++) begin
         @(negedge clk);
         if (cyc_set) found = 1;
      end
      chk("R9 start pulses resume", found, 1);
   endtask

   initial begin
      fork
         begin
            main();
         end
         begin
            repeat (190000) @(posedge clk);
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      disable fork;
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

endmodule